// File: doc/BRIEF.md
# Addressed configuration shift chain

This block is the serial configuration port of a 32-channel readout chip. Twelve shift registers of very different lengths (1 to 320 bits) sit behind one four-pin interface: a serial data input, a shift clock, a strobe and a serial data output. The host opens a frame by shifting a 4-bit register address, then shifts the new contents of that register. The old contents leave on the serial output at the same time, so a register can be read back. A rising strobe copies the addressed shift register into a parallel shadow copy. The rest of the chip sees only the shadow copy.

All three serial inputs are treated as asynchronous to the block clock. Each passes through a two-stage synchronizer, and rising edges are detected on the synchronized levels. The host must therefore hold every level of the shift clock and the strobe for at least two block clock cycles. The shadow copies drive the chip-side outputs: the channel gain codes, the thresholds, the per-channel enables, the multiplicity count and the panic-mode flag.

Top module: `cfgchain_top`

## Requirements
- R1: After reset every shadow output and `dout` are 0.
- R2: After reset and after every strobe rising edge, the first four shift clock rising edges shift a register address MSB-first. The lengths of the twelve registers, by address 1 to 12, are 32, 320, 256, 256, 96, 1, 32, 32, 5, 32, 96 and 96 bits.
- R3: Each shift clock rising edge after the address shifts `din` into the top bit of the addressed register, and every bit moves one place toward bit 0. Data sent LSB first therefore lands in place after as many edges as the register has bits.
- R4: During the data phase of a valid address, `dout` shows bit 0 of the addressed shift register, which is the bit the next edge pushes out. During the address phase, and for an invalid address, `dout` is 0.
- R5: A strobe rising edge after a complete valid address copies the addressed shift register into its shadow. Shadow outputs change at no other time. The strobe also ends the frame.
- R6: Addresses 0, 13, 14 and 15 select nothing. Data edges shift no register and a strobe changes no shadow.
- R7: A register that is not addressed neither shifts nor loads.
- R8: In `sampler_short`, `analog_on` and `chan_read`, bit i belongs to channel i, with channel 0 as the LSB. `panic_mode` is 1 for panic mode and 0 for normal mode (register 6).
- R9: When a shift clock edge and a strobe edge are detected in the same cycle, the bit is shifted first. The shadow then captures the contents including that bit.
- R10: A strobe before the fourth address edge loads nothing and restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| din | input | 1 | Serial data in (asynchronous) |
| sck | input | 1 | Shift clock, rising edge active (asynchronous) |
| strobe | input | 1 | Load strobe, rising edge active (asynchronous) |
| dout | output | 1 | Serial readback of the addressed register |
| spare_word | output | 32 | Shadow of register 1 |
| vcm_code | output | 320 | Shadow of register 2, common-mode DAC codes |
| vth_high | output | 256 | Shadow of register 3, high-threshold DAC codes |
| vth_low | output | 256 | Shadow of register 4, low-threshold DAC codes |
| gain_sel | output | 96 | Shadow of register 5, integrator gain codes |
| panic_mode | output | 1 | Shadow of register 6, 1 selects panic mode |
| sampler_short | output | 32 | Shadow of register 7, per-channel sampler bypass |
| analog_on | output | 32 | Shadow of register 8, per-channel analog enable |
| hit_need | output | 5 | Shadow of register 9, channels needed before reading |
| chan_read | output | 32 | Shadow of register 10, per-channel read select |
| aux_trim_a | output | 96 | Shadow of register 11 |
| aux_trim_b | output | 96 | Shadow of register 12 |

## Verification
The shift of a data bit and the strobe load can fall in the same cycle. The bench provokes this by raising the shift clock and the strobe on the same block clock edge, both on the last bit of a frame and at random in later frames. It passes only if the shadow holds the contents including that final bit. The bench also raises the strobe partway through the address, and it sends frames to unused addresses. In both cases it compares all twelve shadow outputs against its own model.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;
    localparam int NREG   = 12;
    localparam int ADDR_W = 4;
    localparam int MAXLEN = 320;

    function automatic int reg_len(input int a);
        case (a)
            1:       return 32;
            2:       return 320;
            3:       return 256;
            4:       return 256;
            5:       return 96;
            6:       return 1;
            7:       return 32;
            8:       return 32;
            9:       return 5;
            10:      return 32;
            11:      return 96;
            12:      return 96;
            default: return 0;
        endcase
    endfunction

    function automatic int reg_off(input int a);
        int s;
        s = 0;
        for (int k = 1; k < a; k++) s += reg_len(k);
        return s;
    endfunction

    localparam int TOTAL_BITS = reg_off(NREG + 1);
endpackage

// File: rtl/cfgchain_sync.sv
module cfgchain_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_a,
    input  logic sck_a,
    input  logic stb_a,
    output logic din_s,
    output logic sck_rise,
    output logic stb_rise
);
    typedef struct packed {
        logic [STAGES:0]   sck;
        logic [STAGES:0]   stb;
        logic [STAGES-1:0] dat;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sck = {st_q.sck[STAGES-1:0], sck_a};
        st_d.stb = {st_q.stb[STAGES-1:0], stb_a};
        st_d.dat = {st_q.dat[STAGES-2:0], din_a};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign din_s    = st_q.dat[STAGES-1];
    assign sck_rise = st_q.sck[STAGES-1] & ~st_q.sck[STAGES];
    assign stb_rise = st_q.stb[STAGES-1] & ~st_q.stb[STAGES];

    // a detected rise cannot repeat in the very next cycle
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> !sck_rise);
endmodule

// File: rtl/cfgchain_ctrl.sv
module cfgchain_ctrl
    import cfgchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              sck_rise,
    input  logic              stb_rise,
    output logic              shift_en,
    output logic              load_en,
    output logic [ADDR_W-1:0] sel,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(ADDR_W);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NREG);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } ctl_t;

    ctl_t st_d, st_q;
    logic done_nx;

    function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
        return (a != '0) && (a <= TOP_ADDR);
    endfunction

    always_comb begin
        st_d = st_q;
        if (sck_rise && st_q.cnt != CNT_FULL) begin
            st_d.addr = {st_q.addr[ADDR_W-2:0], bit_in};
            st_d.cnt  = st_q.cnt + 1'b1;
        end
        done_nx  = (st_d.cnt == CNT_FULL);
        sel      = st_d.addr;
        shift_en = sck_rise && (st_q.cnt == CNT_FULL) && addr_ok(st_q.addr);
        load_en  = stb_rise && done_nx && addr_ok(st_d.addr);
        if (stb_rise) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = (st_q.cnt == CNT_FULL) && addr_ok(st_q.addr);
    assign rd_addr  = st_q.addr;

    assert_load_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (sel != '0 && sel <= TOP_ADDR));
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);
    assert_strobe_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise |=> st_q.cnt == '0);
endmodule

// File: rtl/cfgchain_cell.sv
module cfgchain_cell #(
    parameter int LEN = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           din,
    input  logic           shift_en,
    input  logic           load_en,
    output logic [LEN-1:0] shadow,
    output logic           low_bit
);
    typedef struct packed {
        logic [LEN-1:0] sh;
        logic [LEN-1:0] shd;
    } cell_t;

    cell_t st_d, st_q;
    logic [LEN-1:0] sh_moved;

    generate
        if (LEN == 1) begin : g_one
            assign sh_moved = din;
        end else begin : g_many
            assign sh_moved = {din, st_q.sh[LEN-1:1]};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.sh  = sh_moved;
        if (load_en)  st_d.shd = st_d.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow  = st_q.shd;
    assign low_bit = st_q.sh[0];

    assert_shift_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> st_q.sh[LEN-1] == $past(din));
    assert_sh_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.sh));
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(st_q.shd));
    assert_coincide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && load_en) |=> st_q.shd[LEN-1] == $past(din));
endmodule

// File: rtl/cfgchain_top.sv
module cfgchain_top
    import cfgchain_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         din,
    input  logic         sck,
    input  logic         strobe,
    output logic         dout,
    output logic [31:0]  spare_word,
    output logic [319:0] vcm_code,
    output logic [255:0] vth_high,
    output logic [255:0] vth_low,
    output logic [95:0]  gain_sel,
    output logic         panic_mode,
    output logic [31:0]  sampler_short,
    output logic [31:0]  analog_on,
    output logic [4:0]   hit_need,
    output logic [31:0]  chan_read,
    output logic [95:0]  aux_trim_a,
    output logic [95:0]  aux_trim_b
);
    logic din_s, sck_rise, stb_rise;
    logic shift_en, load_en, rd_valid;
    logic [ADDR_W-1:0] sel, rd_addr;
    logic [TOTAL_BITS-1:0] all_shd;
    logic [NREG-1:0] low_bits;

    cfgchain_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din_a(din), .sck_a(sck), .stb_a(strobe),
        .din_s(din_s), .sck_rise(sck_rise), .stb_rise(stb_rise)
    );

    cfgchain_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_in(din_s), .sck_rise(sck_rise),
        .stb_rise(stb_rise), .shift_en(shift_en), .load_en(load_en),
        .sel(sel), .rd_valid(rd_valid), .rd_addr(rd_addr)
    );

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            localparam int L = reg_len(i + 1);
            localparam int O = reg_off(i + 1);
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
            logic hit;
            assign hit = (sel == MY_ADDR);
            cfgchain_cell #(.LEN(L)) u_cell (
                .clk(clk), .rst_n(rst_n), .din(din_s),
                .shift_en(shift_en && hit), .load_en(load_en && hit),
                .shadow(all_shd[O +: L]), .low_bit(low_bits[i])
            );
        end
    endgenerate

    always_comb begin
        dout = 1'b0;
        for (int k = 0; k < NREG; k++)
            if (rd_valid && rd_addr == ADDR_W'(k + 1)) dout = low_bits[k];
    end

    assign spare_word    = all_shd[reg_off(1)  +: 32];
    assign vcm_code      = all_shd[reg_off(2)  +: 320];
    assign vth_high      = all_shd[reg_off(3)  +: 256];
    assign vth_low       = all_shd[reg_off(4)  +: 256];
    assign gain_sel      = all_shd[reg_off(5)  +: 96];
    assign panic_mode    = all_shd[reg_off(6)];
    assign sampler_short = all_shd[reg_off(7)  +: 32];
    assign analog_on     = all_shd[reg_off(8)  +: 32];
    assign hit_need      = all_shd[reg_off(9)  +: 5];
    assign chan_read     = all_shd[reg_off(10) +: 32];
    assign aux_trim_a    = all_shd[reg_off(11) +: 96];
    assign aux_trim_b    = all_shd[reg_off(12) +: 96];

    assert_outputs_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(all_shd));
    assert_dout_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && !sck_rise) |=> !dout);
endmodule

// File: tb/cfgchain_top_test.sv
module cfgchain_top_test;
    logic clk = 1'b0, rst_n = 1'b0, din = 1'b0, sck = 1'b0, strobe = 1'b0;
    logic dout, panic_mode;
    logic [31:0]  spare_word, sampler_short, analog_on, chan_read;
    logic [319:0] vcm_code;
    logic [255:0] vth_high, vth_low;
    logic [95:0]  gain_sel, aux_trim_a, aux_trim_b;
    logic [4:0]   hit_need;

    always #2 clk = ~clk;

    cfgchain_top uut (
        .clk(clk), .rst_n(rst_n), .din(din), .sck(sck), .strobe(strobe),
        .dout(dout), .spare_word(spare_word), .vcm_code(vcm_code),
        .vth_high(vth_high), .vth_low(vth_low), .gain_sel(gain_sel),
        .panic_mode(panic_mode), .sampler_short(sampler_short),
        .analog_on(analog_on), .hit_need(hit_need), .chan_read(chan_read),
        .aux_trim_a(aux_trim_a), .aux_trim_b(aux_trim_b)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [319:0] m_sh  [1:12];
    logic [319:0] m_shd [1:12];
    int  b_cnt = 0;
    logic [3:0] b_addr = '0;

    function automatic int len_of(input int a);
        int t[12] = '{32, 320, 256, 256, 96, 1, 32, 32, 5, 32, 96, 96};
        return (a >= 1 && a <= 12) ? t[a-1] : 0;
    endfunction

    function automatic logic [319:0] port_val(input int a);
        logic [319:0] v;
        v = '0;
        case (a)
            1:  v[31:0]  = spare_word;
            2:  v        = vcm_code;
            3:  v[255:0] = vth_high;
            4:  v[255:0] = vth_low;
            5:  v[95:0]  = gain_sel;
            6:  v[0]     = panic_mode;
            7:  v[31:0]  = sampler_short;
            8:  v[31:0]  = analog_on;
            9:  v[4:0]   = hit_need;
            10: v[31:0]  = chan_read;
            11: v[95:0]  = aux_trim_a;
            default: v[95:0] = aux_trim_b;
        endcase
        return v;
    endfunction

    task automatic chk(input string req, input logic [319:0] act, input logic [319:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_strobe();
        if (b_cnt == 4 && len_of(int'(b_addr)) > 0) m_shd[b_addr] = m_sh[b_addr];
        b_cnt = 0;
    endtask

    task automatic check_all(input string req);
        for (int a = 1; a <= 12; a++) chk(req, port_val(a), m_shd[a]);
    endtask

    // one shift clock pulse; optionally the strobe rises on the same edge
    task automatic sc_edge(input logic b, input bit with_stb);
        int L;
        L = len_of(int'(b_addr));
        chk("R4 dout", {319'b0, dout},
            {319'b0, (b_cnt == 4 && L > 0) ? m_sh[b_addr][0] : 1'b0});
        din = b;
        wait_clks(1);
        sck = 1'b1;
        if (with_stb) strobe = 1'b1;
        wait_clks(4);
        sck = 1'b0;
        strobe = 1'b0;
        wait_clks(4);
        if (b_cnt < 4) begin
            b_addr = {b_addr[2:0], b};
            b_cnt++;
        end else if (L > 0) begin
            m_sh[b_addr] = (m_sh[b_addr] >> 1) | ({319'b0, b} << (L - 1));
        end
        if (with_stb) model_strobe();
    endtask

    task automatic strobe_pulse();
        strobe = 1'b1;
        wait_clks(4);
        strobe = 1'b0;
        wait_clks(4);
        model_strobe();
    endtask

    task automatic send_frame(input logic [3:0] a, input int nbits,
                              input logic [319:0] data, input bit coincide);
        for (int i = 3; i >= 0; i--) sc_edge(a[i], 1'b0);
        for (int i = 0; i < nbits; i++) sc_edge(data[i], coincide && i == nbits - 1);
        if (!coincide) strobe_pulse();
    endtask

    initial begin
        wait_clks(200000);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [319:0] d;
        int a, n;
        void'($urandom(32'd7341));
        for (int k = 1; k <= 12; k++) begin m_sh[k] = '0; m_shd[k] = '0; end
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(3);
        // R1: reset state
        chk("R1 dout", {319'b0, dout}, '0);
        check_all("R1");

        // R8: channel 5 analog enable; outputs unchanged before strobe (R5)
        for (int i = 3; i >= 0; i--) sc_edge(4'd8 >> i, 1'b0);
        for (int i = 0; i < 32; i++) sc_edge(i == 5, 1'b0);
        chk("R5 no change before strobe", {288'b0, analog_on}, '0);
        strobe_pulse();
        chk("R8 channel 5 bit", {319'b0, analog_on[5]}, 320'd1);
        chk("R8 single channel", 320'($countones(analog_on)), 320'd1);
        check_all("R3 R5 R7");

        // R8: panic mode, one-bit register
        send_frame(4'd6, 1, 320'd1, 1'b0);
        chk("R8 panic", {319'b0, panic_mode}, 320'd1);

        // R9: last bit coincides with strobe
        send_frame(4'd9, 5, 320'h1f, 1'b1);
        chk("R9 coincident load", {315'b0, hit_need}, 320'h1f);
        check_all("R9");

        // R4: readback of the old contents while writing new
        send_frame(4'd9, 5, 320'h0a, 1'b0);
        chk("R4 R3 new value", {315'b0, hit_need}, 320'h0a);

        // R6: invalid addresses change nothing
        send_frame(4'd14, 20, 320'hfffff, 1'b0);
        check_all("R6 addr14");
        send_frame(4'd0, 8, 320'hff, 1'b0);
        check_all("R6 addr0");

        // R10: strobe after two address bits
        sc_edge(1'b1, 1'b0);
        sc_edge(1'b0, 1'b0);
        strobe_pulse();
        check_all("R10");
        send_frame(4'd10, 32, 320'h0000_0100, 1'b0);
        chk("R10 R2 frame after abort", {288'b0, chan_read}, 320'h100);

        // R2 R3: longest register
        d = '0;
        for (int w = 0; w < 10; w++) d[w*32 +: 32] = $urandom();
        send_frame(4'd2, 320, d, 1'b0);
        chk("R2 R3 longest", vcm_code, d);

        // random frames
        for (int f = 0; f < 30; f++) begin
            a = $urandom_range(0, 15);
            d = '0;
            for (int w = 0; w < 10; w++) d[w*32 +: 32] = $urandom();
            if (len_of(a) > 0)
                n = ($urandom_range(0, 3) == 0) ? $urandom_range(1, len_of(a)) : len_of(a);
            else
                n = $urandom_range(1, 40);
            send_frame(4'(a), n, d, $urandom_range(0, 3) == 0);
            check_all("R3 R5 R6 R7 R9 random");
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule